// File: doc/BRIEF.md
# Multi-Channel Successive-Approximation Converter Controller

This block holds the digital half of a 10-bit successive-approximation converter that serves eight multiplexed analog inputs. It divides the bus clock down to a slower conversion clock. It drives the channel select and the trial code for an external DAC, and it reads back a single comparator bit. It then builds each result one bit at a time, starting from the top bit. The comparator, the DAC and the sample-and-hold sit outside the block.

Software uses a small word-wide register port. A control word sets the channel mask, the divider, the run mode and the start source. An interrupt mask sets which channels may raise the interrupt line. A status word gathers the per-channel flags. Each channel has its own result word. A conversion can start from a software start bit, from a selected edge on an external trigger pin, or from a timer match pulse. Burst mode instead scans the selected channels again and again without software help.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A conversion tests bits 9 down to 0 in turn. Each trial code keeps the bits already decided, with the current bit set. A bit stays set only when the comparator input is high for that code (high means the input is at or above the code). An input level from 0 to 1023 therefore yields exactly that level as the result.
- R2: A single conversion converts the lowest-numbered channel in the mask (control bits [7:0]). The mux select does not change while the bit trials run. With an empty mask, no conversion starts.
- R3: The conversion clock period is DIV+1 bus cycles (DIV is control bits [15:8]). A conversion lasts 11 conversion-clock periods: one sample period (sample output high) and then ten bit trials. The result flag appears 1+11*(DIV+1) clock edges after the edge that writes the start.
- R4: Writing the control word (address 0) with bit 21 set starts one single conversion. Bit 21 always reads back as 0, and the other fields read back as written.
- R5: With source field [19:18] = 1, an edge on the trigger pin starts a single conversion. The pin passes through a two-flop synchronizer. Bit 20 picks the edge: 0 for rising, 1 for falling. The other edge is ignored.
- R6: With source field = 2, a rising edge of the timer match input starts a single conversion. Trigger pin edges are then ignored.
- R7: With burst (bit 16) set, the block converts every channel in the mask in turn. It starts at the lowest channel, moves upward and wraps around, with no further start requests.
- R8: Clearing burst lets the conversion in progress finish and store its result. After that, no new conversion starts.
- R9: While enable (bit 17) is clear, the block stays idle and ignores every start source. Clearing it during a conversion abandons that conversion and stores no result.
- R10: Each result word (address 8+n) holds the value in [9:0], OVERRUN in bit 30 and DONE in bit 31. A new result sets DONE. A read of that word clears DONE and OVERRUN. Reset clears all registers.
- R11: OVERRUN is set when a new result replaces one whose DONE flag was still set. The status word (address 2) shows DONE flags in [7:0], OVERRUN flags in [15:8], busy in bit 16 and the interrupt in bit 17.
- R12: The interrupt output is high whenever any channel has DONE set and its bit set in the interrupt mask (address 1, bits [7:0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; reading a result word clears its flags |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| cmp_in | input | 1 | Comparator result: input at or above the DAC code |
| trig_pin | input | 1 | Asynchronous external trigger pin |
| timer_match | input | 1 | Synchronous timer match pulse |
| dac_code | output | 10 | Trial code for the external DAC |
| mux_sel | output | 3 | Analog input select |
| sample_en | output | 1 | High during the sample period |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check four things. The first trial code is the top bit alone. The mux select is held through the bit trials. Each stored result comes on the eleventh conversion-clock tick. Dropping enable returns the engine to idle. They also check that a result read clears DONE, and that a result landing on an unread one raises OVERRUN. Only the bench scenarios can show the rest: the converted values against modelled input levels, the exact cycle count for a given divider, the edge polarity of the pin trigger, the burst channel order and the clean stop, and the interrupt masking.

// File: rtl/adc_pkg.sv
package adc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_CONV} sar_state_e;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_IMASK    = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_STATUS   = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_RES_BASE = 4'd8;

  localparam int CTL_DIV_LSB = 8;
  localparam int CTL_BURST   = 16;
  localparam int CTL_EN      = 17;
  localparam int CTL_SRC_LSB = 18;
  localparam int CTL_FALL    = 20;
  localparam int CTL_GO      = 21;

  localparam int STAT_OVR_LSB = 8;
  localparam int STAT_BUSY    = 16;
  localparam int STAT_IRQ     = 17;

  localparam int RES_OVR_BIT  = 30;
  localparam int RES_DONE_BIT = 31;

  localparam logic [1:0] SRC_NONE  = 2'd0;
  localparam logic [1:0] SRC_PIN   = 2'd1;
  localparam logic [1:0] SRC_TIMER = 2'd2;
endpackage

// File: rtl/adc_clkdiv.sv
module adc_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic tmr,
  output logic pin_rise,
  output logic pin_fall,
  output logic tmr_rise
);
  logic s1_q, s2_q, s3_q, tmr_q;

  assign pin_rise = s2_q & ~s3_q;
  assign pin_fall = ~s2_q & s3_q;
  assign tmr_rise = tmr & ~tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      tmr_q <= 1'b0;
    end else begin
      s1_q  <= pin;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      tmr_q <= tmr;
    end
  end
endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine
  import adc_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int RES_W = 10,
  localparam int CH_W  = $clog2(NCH),
  localparam int BIT_W = $clog2(RES_W),
  localparam int TC_W  = $clog2(RES_W + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             burst,
  input  logic [NCH-1:0]   mask,
  input  logic             start,
  input  logic             tick,
  input  logic             cmp_in,
  output logic             busy,
  output logic             sample_en,
  output logic [RES_W-1:0] dac_code,
  output logic [CH_W-1:0]  mux_sel,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic [CH_W-1:0]  res_chan
);
  sar_state_e       state_q, state_d;
  logic [RES_W-1:0] sar_q, sar_d, sar_tmp;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [CH_W-1:0]  chan_q, chan_d;
  logic [TC_W-1:0]  tc_q, tc_d;

  function automatic logic [CH_W-1:0] pick_chan(input logic [NCH-1:0] m,
                                                input logic [CH_W-1:0] cur,
                                                input logic after_cur);
    logic [CH_W-1:0] lo, nx;
    logic found;
    lo = '0;
    nx = '0;
    found = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (m[i]) lo = i[CH_W-1:0];
      if (m[i] && (i > int'(cur))) begin
        nx = i[CH_W-1:0];
        found = 1'b1;
      end
    end
    return (after_cur && found) ? nx : lo;
  endfunction

  always_comb begin
    state_d   = state_q;
    sar_d     = sar_q;
    bit_d     = bit_q;
    chan_d    = chan_q;
    sar_tmp   = sar_q;
    res_valid = 1'b0;
    res_data  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (en && (mask != '0) && (burst || start)) begin
          state_d = ST_SAMPLE;
          sar_d   = '0;
          chan_d  = pick_chan(mask, chan_q, 1'b0);
        end
      end
      ST_SAMPLE: begin
        if (!en) begin
          state_d = ST_IDLE;
          sar_d   = '0;
        end else if (tick) begin
          state_d            = ST_CONV;
          sar_d              = '0;
          sar_d[RES_W-1]     = 1'b1;
          bit_d              = BIT_W'(RES_W - 1);
        end
      end
      ST_CONV: begin
        if (!en) begin
          state_d = ST_IDLE;
          sar_d   = '0;
        end else if (tick) begin
          if (!cmp_in) sar_tmp[bit_q] = 1'b0;
          if (bit_q == '0) begin
            res_valid = 1'b1;
            res_data  = sar_tmp;
            sar_d     = '0;
            if (burst && (mask != '0)) begin
              state_d = ST_SAMPLE;
              chan_d  = pick_chan(mask, chan_q, 1'b1);
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            sar_tmp[bit_q - 1'b1] = 1'b1;
            sar_d = sar_tmp;
            bit_d = bit_q - 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if ((state_q == ST_IDLE) || res_valid) tc_d = '0;
    else if (tick)                         tc_d = tc_q + 1'b1;
    else                                   tc_d = tc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sar_q   <= '0;
      bit_q   <= '0;
      chan_q  <= '0;
      tc_q    <= '0;
    end else begin
      state_q <= state_d;
      sar_q   <= sar_d;
      bit_q   <= bit_d;
      chan_q  <= chan_d;
      tc_q    <= tc_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign sample_en = (state_q == ST_SAMPLE);
  assign dac_code  = sar_q;
  assign mux_sel   = chan_q;
  assign res_chan  = chan_q;

  AST_SAR_MSB_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV && $past(state_q) == ST_SAMPLE) |-> (dac_code == {1'b1, {(RES_W-1){1'b0}}})); // R1
  AST_MUX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV) |-> $stable(mux_sel)); // R2
  AST_ELEVEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (tc_q == TC_W'(RES_W))); // R3
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy); // R9
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NCH   = 8,
  parameter int RES_W = 10,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_valid,
  input  logic [CH_W-1:0]           wr_chan,
  input  logic [RES_W-1:0]          wr_data,
  input  logic [NCH-1:0]            rd_clr,
  output logic [NCH-1:0][RES_W-1:0] value,
  output logic [NCH-1:0]            done,
  output logic [NCH-1:0]            ovr
);
  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic             hit;
    logic [RES_W-1:0] val_q, val_d;
    logic             done_q, done_d, ovr_q, ovr_d;

    assign hit = wr_valid && (wr_chan == CH_W'(g));

    always_comb begin
      val_d  = val_q;
      done_d = done_q;
      ovr_d  = ovr_q;
      if (rd_clr[g]) begin
        done_d = 1'b0;
        ovr_d  = 1'b0;
      end
      if (hit) begin
        val_d  = wr_data;
        done_d = 1'b1;
        ovr_d  = (done_q && !rd_clr[g]) || (ovr_q && !rd_clr[g]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q  <= '0;
        done_q <= 1'b0;
        ovr_q  <= 1'b0;
      end else begin
        val_q  <= val_d;
        done_q <= done_d;
        ovr_q  <= ovr_d;
      end
    end

    assign value[g] = val_q;
    assign done[g]  = done_q;
    assign ovr[g]   = ovr_q;

    AST_READ_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr[g] && !hit) |=> !done[g]); // R10
    AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && done[g] && !rd_clr[g]) |=> ovr[g]); // R11
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import adc_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int RES_W = 10,
  parameter int DIV_W = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cmp_in,
  input  logic              trig_pin,
  input  logic              timer_match,
  output logic [RES_W-1:0]  dac_code,
  output logic [CH_W-1:0]   mux_sel,
  output logic              sample_en,
  output logic              irq
);
  logic rst_s1, rst_s2, rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  assign rst_n_int = rst_s2;

  logic [NCH-1:0]   mask_q, mask_d, imask_q, imask_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             burst_q, burst_d, en_q, en_d, fall_q, fall_d, go_q, go_d;
  logic [1:0]       src_q, src_d;
  logic             ctrl_we, imask_we;
  logic             unused_wdata;

  assign ctrl_we      = reg_wr && (reg_addr == ADDR_CTRL);
  assign imask_we     = reg_wr && (reg_addr == ADDR_IMASK);
  assign unused_wdata = ^reg_wdata[DATA_W-1:CTL_GO+1];

  always_comb begin
    mask_d  = mask_q;
    div_d   = div_q;
    burst_d = burst_q;
    en_d    = en_q;
    src_d   = src_q;
    fall_d  = fall_q;
    imask_d = imask_q;
    go_d    = 1'b0;
    if (ctrl_we) begin
      mask_d  = reg_wdata[NCH-1:0];
      div_d   = reg_wdata[CTL_DIV_LSB +: DIV_W];
      burst_d = reg_wdata[CTL_BURST];
      en_d    = reg_wdata[CTL_EN];
      src_d   = reg_wdata[CTL_SRC_LSB +: 2];
      fall_d  = reg_wdata[CTL_FALL];
      go_d    = reg_wdata[CTL_GO];
    end
    if (imask_we) imask_d = reg_wdata[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      mask_q  <= '0;
      div_q   <= '0;
      burst_q <= 1'b0;
      en_q    <= 1'b0;
      src_q   <= SRC_NONE;
      fall_q  <= 1'b0;
      imask_q <= '0;
      go_q    <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      div_q   <= div_d;
      burst_q <= burst_d;
      en_q    <= en_d;
      src_q   <= src_d;
      fall_q  <= fall_d;
      imask_q <= imask_d;
      go_q    <= go_d;
    end
  end

  logic pin_rise, pin_fall, tmr_rise, start, tick, busy;
  logic res_valid;
  logic [RES_W-1:0] res_data;
  logic [CH_W-1:0]  res_chan;
  logic [NCH-1:0][RES_W-1:0] res_val;
  logic [NCH-1:0] done_vec, ovr_vec, rd_clr;

  adc_trig_sync u_trig (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .pin      (trig_pin),
    .tmr      (timer_match),
    .pin_rise (pin_rise),
    .pin_fall (pin_fall),
    .tmr_rise (tmr_rise)
  );

  assign start = go_q
              || ((src_q == SRC_PIN) && (fall_q ? pin_fall : pin_rise))
              || ((src_q == SRC_TIMER) && tmr_rise);

  adc_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n_int),
    .run   (busy),
    .div   (div_q),
    .tick  (tick)
  );

  adc_sar_engine #(.NCH(NCH), .RES_W(RES_W)) u_sar (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .en        (en_q),
    .burst     (burst_q),
    .mask      (mask_q),
    .start     (start),
    .tick      (tick),
    .cmp_in    (cmp_in),
    .busy      (busy),
    .sample_en (sample_en),
    .dac_code  (dac_code),
    .mux_sel   (mux_sel),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_chan  (res_chan)
  );

  always_comb begin
    for (int i = 0; i < NCH; i++)
      rd_clr[i] = reg_rd && (reg_addr == ADDR_RES_BASE + i[ADDR_W-1:0]);
  end

  adc_result_bank #(.NCH(NCH), .RES_W(RES_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_valid (res_valid),
    .wr_chan  (res_chan),
    .wr_data  (res_data),
    .rd_clr   (rd_clr),
    .value    (res_val),
    .done     (done_vec),
    .ovr      (ovr_vec)
  );

  assign irq = |(done_vec & imask_q);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_CTRL) begin
      reg_rdata[NCH-1:0]              = mask_q;
      reg_rdata[CTL_DIV_LSB +: DIV_W] = div_q;
      reg_rdata[CTL_BURST]            = burst_q;
      reg_rdata[CTL_EN]               = en_q;
      reg_rdata[CTL_SRC_LSB +: 2]     = src_q;
      reg_rdata[CTL_FALL]             = fall_q;
    end else if (reg_addr == ADDR_IMASK) begin
      reg_rdata[NCH-1:0] = imask_q;
    end else if (reg_addr == ADDR_STATUS) begin
      reg_rdata[NCH-1:0]             = done_vec;
      reg_rdata[STAT_OVR_LSB +: NCH] = ovr_vec;
      reg_rdata[STAT_BUSY]           = busy;
      reg_rdata[STAT_IRQ]            = irq;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (reg_addr == ADDR_RES_BASE + i[ADDR_W-1:0]) begin
          reg_rdata[RES_W-1:0]    = res_val[i];
          reg_rdata[RES_OVR_BIT]  = ovr_vec[i];
          reg_rdata[RES_DONE_BIT] = done_vec[i];
        end
      end
    end
  end
endmodule

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata, reg_rdata;
  logic        cmp_in, trig_pin, timer_match;
  logic [9:0]  dac_code;
  logic [2:0]  mux_sel;
  logic        sample_en, irq;

  int vin [8];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  int order [8];
  int rec_idx = 0;
  bit rec_on = 0;
  logic prev_samp = 1'b0;

  always #10 clk = ~clk;

  assign cmp_in = (vin[mux_sel] >= int'(dac_code));

  sar_adc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_in(cmp_in), .trig_pin(trig_pin),
    .timer_match(timer_match), .dac_code(dac_code), .mux_sel(mux_sel),
    .sample_en(sample_en), .irq(irq)
  );

  always @(negedge clk) begin
    if (rec_on && sample_en && !prev_samp && rec_idx < 8) begin
      order[rec_idx] = int'(mux_sel);
      rec_idx = rec_idx + 1;
    end
    prev_samp = sample_en;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input int mask, input int div, input bit burst,
                                          input bit en, input int src, input bit fall, input bit go);
    logic [31:0] w;
    w = '0;
    w[7:0]   = mask[7:0];
    w[15:8]  = div[7:0];
    w[16]    = burst;
    w[17]    = en;
    w[19:18] = src[1:0];
    w[20]    = fall;
    w[21]    = go;
    return w;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #2 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_stat(input int idx, input int lim, output int n, output bit ok);
    reg_addr = 4'd2;
    n = 0; ok = 0;
    while (n < lim && !ok) begin
      @(posedge clk); #1;
      n++;
      if (reg_rdata[idx]) ok = 1;
    end
  endtask

  task automatic clear_all();
    logic [31:0] d;
    for (int c = 0; c < 8; c++) rd(4'd8 + 4'(c), d);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    peek(4'd0, d); chk("R10 reset ctrl", int'(d), 0);
    peek(4'd2, d); chk("R10 reset status", int'(d), 0);
    chk("R12 reset irq", int'(irq), 0);
    chk("R1 reset dac", int'(dac_code), 0);
  endtask

  task automatic t_single();
    logic [31:0] d; int n; bit ok;
    vin[3] = 677; vin[6] = 300;
    wr(4'd0, mk_ctrl(8'h48, 2, 0, 1, 0, 0, 1));
    wait_stat(3, 300, n, ok);
    chk("R3 cycles div2", n, 1 + 11 * 3);
    rd(4'd11, d);
    chk("R1 value ch3", int'(d[9:0]), 677);
    chk("R10 done ch3", int'(d[31]), 1);
    peek(4'd2, d);
    chk("R2 lowest channel only", int'(d[6]), 0);
    peek(4'd0, d);
    chk("R4 go reads zero", int'(d[21]), 0);
    chk("R4 fields read back", int'(d[20:0]), int'(mk_ctrl(8'h48, 2, 0, 1, 0, 0, 0)));
    foreach (vin[k]) if (k == 0) vin[k] = 0;
    wr(4'd0, mk_ctrl(8'h01, 0, 0, 1, 0, 0, 1));
    wait_stat(0, 300, n, ok);
    chk("R3 cycles div0", n, 12);
    rd(4'd8, d); chk("R1 value zero", int'(d[9:0]), 0);
    vin[0] = 1023;
    wr(4'd0, mk_ctrl(8'h01, 0, 0, 1, 0, 0, 1));
    wait_stat(0, 300, n, ok);
    rd(4'd8, d); chk("R1 value full", int'(d[9:0]), 1023);
    vin[0] = 511;
    wr(4'd0, mk_ctrl(8'h01, 1, 0, 1, 0, 0, 1));
    wait_stat(0, 300, n, ok);
    chk("R3 cycles div1", n, 23);
    rd(4'd8, d); chk("R1 value 511", int'(d[9:0]), 511);
    wr(4'd0, mk_ctrl(8'h00, 0, 0, 1, 0, 0, 1));
    repeat (40) @(posedge clk);
    #1 peek(4'd2, d);
    chk("R2 empty mask no start", int'(d[16:0]), 0);
  endtask

  task automatic t_overrun();
    logic [31:0] d; int n; bit ok;
    clear_all();
    vin[3] = 100;
    wr(4'd0, mk_ctrl(8'h08, 0, 0, 1, 0, 0, 1));
    wait_stat(3, 100, n, ok);
    vin[3] = 200;
    wr(4'd0, mk_ctrl(8'h08, 0, 0, 1, 0, 0, 1));
    repeat (40) @(posedge clk);
    #1 peek(4'd2, d);
    chk("R11 status overrun ch3", int'(d[11]), 1);
    rd(4'd11, d);
    chk("R11 overrun set", int'(d[30]), 1);
    chk("R11 newer value kept", int'(d[9:0]), 200);
    rd(4'd11, d);
    chk("R10 read clears done", int'(d[31]), 0);
    chk("R10 read clears overrun", int'(d[30]), 0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    clear_all();
    vin[1] = 400;
    wr(4'd0, mk_ctrl(8'h02, 0, 0, 0, 0, 0, 1));
    repeat (60) @(posedge clk);
    #1 peek(4'd2, d);
    chk("R9 start ignored while off", int'(d[16:0]), 0);
    wr(4'd0, mk_ctrl(8'h02, 50, 0, 1, 0, 0, 1));
    repeat (30) @(posedge clk);
    #1 peek(4'd2, d);
    chk("R9 busy after start", int'(d[16]), 1);
    wr(4'd0, mk_ctrl(8'h02, 50, 0, 0, 0, 0, 0));
    repeat (700) @(posedge clk);
    #1 peek(4'd2, d);
    chk("R9 abort stores nothing", int'(d[16:0]), 0);
  endtask

  task automatic t_pin();
    logic [31:0] d; int n; bit ok;
    clear_all();
    vin[4] = 333;
    wr(4'd0, mk_ctrl(8'h10, 0, 0, 1, 1, 0, 0));
    @(negedge clk) trig_pin = 1'b1;
    wait_stat(4, 100, n, ok);
    chk("R5 rising edge start", int'(ok), 1);
    rd(4'd12, d); chk("R5 pin value", int'(d[9:0]), 333);
    wr(4'd0, mk_ctrl(8'h10, 0, 0, 1, 1, 1, 0));
    @(negedge clk) trig_pin = 1'b0;
    wait_stat(4, 100, n, ok);
    chk("R5 falling edge start", int'(ok), 1);
    rd(4'd12, d);
    @(negedge clk) trig_pin = 1'b1;
    repeat (60) @(posedge clk);
    #1 peek(4'd2, d);
    chk("R5 rising ignored when falling chosen", int'(d[16:0]), 0);
  endtask

  task automatic t_timer();
    logic [31:0] d; int n; bit ok;
    clear_all();
    vin[5] = 901;
    wr(4'd0, mk_ctrl(8'h20, 0, 0, 1, 2, 0, 0));
    @(negedge clk) trig_pin = 1'b0;
    repeat (60) @(posedge clk);
    #1 peek(4'd2, d);
    chk("R6 pin ignored in timer mode", int'(d[16:0]), 0);
    @(negedge clk) timer_match = 1'b1;
    @(negedge clk) timer_match = 1'b0;
    wait_stat(5, 100, n, ok);
    chk("R6 timer start", int'(ok), 1);
    rd(4'd13, d); chk("R6 timer value", int'(d[9:0]), 901);
  endtask

  task automatic t_burst();
    logic [31:0] d; int n;
    clear_all();
    vin[2] = 100; vin[5] = 555; vin[7] = 1000;
    rec_idx = 0; rec_on = 1;
    wr(4'd0, mk_ctrl(8'hA4, 0, 1, 1, 0, 0, 0));
    n = 0;
    while (rec_idx < 4 && n < 500) begin @(negedge clk); n++; end
    rd(4'd10, d);
    wr(4'd0, mk_ctrl(8'hA4, 0, 0, 1, 0, 0, 0));
    reg_addr = 4'd2;
    n = 0;
    do begin @(posedge clk); #1; n++; end while (reg_rdata[16] && n < 200);
    repeat (100) @(posedge clk);
    #1;
    chk("R8 no start after burst off", rec_idx, 4);
    chk("R7 order 0", order[0], 2);
    chk("R7 order 1", order[1], 5);
    chk("R7 order 2", order[2], 7);
    chk("R7 order wrap", order[3], 2);
    rec_on = 0;
    rd(4'd10, d);
    chk("R8 last conversion finished", int'(d[31]), 1);
    chk("R8 last value", int'(d[9:0]), 100);
    rd(4'd13, d); chk("R7 ch5 value", int'(d[9:0]), 555);
    rd(4'd15, d); chk("R7 ch7 value", int'(d[9:0]), 1000);
  endtask

  task automatic t_irq();
    logic [31:0] d; int n; bit ok;
    clear_all();
    vin[2] = 50; vin[5] = 60;
    wr(4'd1, 32'h20);
    wr(4'd0, mk_ctrl(8'h04, 0, 0, 1, 0, 0, 1));
    wait_stat(2, 100, n, ok);
    chk("R12 masked channel no irq", int'(irq), 0);
    wr(4'd0, mk_ctrl(8'h20, 0, 0, 1, 0, 0, 1));
    wait_stat(5, 100, n, ok);
    chk("R12 enabled channel irq", int'(irq), 1);
    peek(4'd2, d);
    chk("R11 status irq bit", int'(d[17]), 1);
    rd(4'd13, d);
    chk("R12 irq drops on read", int'(irq), 0);
    wr(4'd1, 32'h04);
    chk("R12 irq from mask change", int'(irq), 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog over all requirements act=%0d exp=%0d", 1, 0);
    finish_run();
  end

  initial begin
    foreach (vin[k]) vin[k] = 0;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    trig_pin = 1'b0; timer_match = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_overrun();
    t_disabled();
    t_pin();
    t_timer();
    t_burst();
    t_irq();
    finish_run();
  end
endmodule